// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block walks a ring of transmit descriptors in memory and feeds the referenced buffer bytes to a MAC transmit byte interface. Each descriptor holds two 32-bit words at `base + 8*index`: the buffer address at offset 0 and a control/status word at offset 4. Software fills descriptors and clears their ownership bit. A start pulse then sets the block going. It fetches each descriptor, streams the buffer out least significant byte first, and writes the control word back with the ownership bit set to show the buffer is done.

A frame may span several buffers. The end-of-frame bit on the final buffer raises the last-byte marker toward the MAC. The frame's first descriptor selects whether the MAC leaves out the CRC. Errors are recorded in the same status word that carries ownership. These are an underrun or retry-limit report from the MAC, and running out of software-released descriptors in the middle of a frame. A halt request lets the current frame finish and then stops the block. Loading the queue pointer while idle sets a new ring base and restarts at entry 0.

The memory port is a simple single-request port. Read data returns on the cycle after a read request, and a write takes effect in its request cycle.

Top module: `txdr_ring_reader`

## Requirements
- R1: After reset, `busy_o`, `tx_valid_o` and `mem_req_o` are low, and they stay low while the block is idle.
- R2: A `start_i` pulse while idle makes `busy_o` high on the next cycle. The block then fetches the control word at `base + 8*index + 4` and then the buffer address at `base + 8*index`.
- R3: A control word with bit 31 (owned by software) set is not sent. Meeting one at the start of a frame ends processing with no memory write, and `busy_o` drops.
- R4: The buffer length is control bits 10:0, and the buffer address is taken as word aligned. Bytes leave in address order, least significant byte of each word first. A zero-length buffer sends no byte but is still written back.
- R5: When control bit 15 is set, `tx_last_o` is high on the final byte of that buffer. Buffers without it emit no `tx_last_o`, and the next descriptor continues the same frame.
- R6: `tx_nocrc_o` equals bit 16 of the frame's first control word on every byte of that frame.
- R7: After a buffer is sent, its control word is written back to `base + 8*index + 4` with bit 31 set and all other bits unchanged.
- R8: After a descriptor whose control bit 30 is set, the next fetch uses index 0. Otherwise the index is incremented.
- R9: If a descriptor with bit 31 set is met after a buffer without bit 15, the frame's first control word is rewritten with bits 31 and 27 set, and the block goes idle.
- R10: A `mac_underrun_i` pulse while a byte is offered stops the buffer. The rest of the buffer is not sent, the control word is written back with bits 31 and 28 set, and the block goes idle without fetching the next descriptor.
- R11: A `mac_retry_i` pulse while a byte is offered behaves like R10 but sets bit 29 instead of bit 28.
- R12: A `halt_i` pulse while busy lets the current frame complete. The block then goes idle, leaves the next descriptor untouched, and resumes from it on the next start.
- R13: A `qp_we_i` write while idle loads the ring base from `qp_data_i` and resets the index to 0. A write while busy is ignored.
- R14: While `tx_valid_o` is high and `tx_ready_i` is low, and no error is reported, the offered byte and its flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-transmit pulse |
| halt_i | input | 1 | Halt request pulse |
| qp_we_i | input | 1 | Queue pointer write strobe |
| qp_data_i | input | ADDR_W | New ring base address |
| busy_o | output | 1 | High while the ring is being processed |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after a read request |
| tx_valid_o | output | 1 | Byte offered to the MAC |
| tx_data_o | output | 8 | Offered byte |
| tx_last_o | output | 1 | Byte ends the frame |
| tx_nocrc_o | output | 1 | MAC should not append a CRC |
| tx_ready_i | input | 1 | MAC takes the byte |
| mac_underrun_i | input | 1 | MAC reports an underrun |
| mac_retry_i | input | 1 | MAC reports the retry limit was exceeded |

## Verification
Frames are tried as a single buffer, as a two-buffer frame with the CRC-suppress flag, and as a zero-length buffer on the ring's wrap entry. These show whether the byte order, the last-byte marker and the index wrap are each handled correctly. A randomly stalling ready exposes byte holding and lane counting that ignore backpressure. Ring exhaustion in mid frame and the two MAC error inputs, raised mid-word during a stall, separate the three status bits and show whether the abort leaves the rest of the ring alone. A halt combined with a queue pointer write during a frame, followed by a restart, shows that the stop falls on a frame boundary and that busy-time pointer writes are dropped.

// File: rtl/txdr_pkg.sv
`timescale 1ns/1ps
package txdr_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 11;
  localparam int OWN_B   = 31;
  localparam int WRAP_B  = 30;
  localparam int RETRY_B = 29;
  localparam int URUN_B  = 28;
  localparam int EXH_B   = 27;
  localparam int NOCRC_B = 16;
  localparam int LAST_B  = 15;

  typedef enum logic [3:0] {
    S_IDLE, S_CREQ, S_CWAIT, S_AREQ, S_AWAIT,
    S_WREQ, S_WWAIT, S_SEND, S_WB, S_EXH
  } txdr_st_t;
endpackage

// File: rtl/tdr_ring_ptr.sv
`timescale 1ns/1ps
module tdr_ring_ptr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_base,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              advance,
  input  logic              wrap,
  input  logic              mark_first,
  output logic [ADDR_W-1:0] buf_word_addr,
  output logic [ADDR_W-1:0] ctrl_word_addr,
  output logic [ADDR_W-1:0] first_ctrl_addr
);
  localparam int PAD_W = ADDR_W - IDX_W - 3;

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      idx_q   <= '0;
      first_q <= '0;
    end else begin
      if (load_base) begin
        base_q <= {base_in[ADDR_W-1:2], 2'b00};
        idx_q  <= '0;
      end else if (advance) begin
        idx_q <= wrap ? '0 : idx_q + 1'b1;
      end
      if (mark_first) first_q <= idx_q;
    end
  end

  assign buf_word_addr   = base_q + {{PAD_W{1'b0}}, idx_q, 3'b000};
  assign ctrl_word_addr  = buf_word_addr + ADDR_W'(4);
  assign first_ctrl_addr = base_q + {{PAD_W{1'b0}}, first_q, 3'b100};
endmodule

// File: rtl/tdr_byte_pack.sv
`timescale 1ns/1ps
module tdr_byte_pack #(
  parameter int LEN_W  = 11,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_len,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              load_word,
  input  logic [WORD_W-1:0] word_in,
  input  logic              pop,
  output logic [7:0]        byte_o,
  output logic              lane_last,
  output logic              buf_last
);
  localparam int LANES = WORD_W / 8;
  localparam int LW    = $clog2(LANES) + 1;

  logic [LEN_W-1:0]  remain_q;
  logic [LW-1:0]     lanes_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      lanes_q  <= '0;
      word_q   <= '0;
    end else if (load_len) begin
      remain_q <= len_in;
    end else if (load_word) begin
      word_q  <= word_in;
      lanes_q <= (remain_q >= LEN_W'(LANES)) ? LW'(LANES) : LW'(remain_q);
    end else if (pop) begin
      word_q   <= word_q >> 8;
      lanes_q  <= lanes_q - 1'b1;
      remain_q <= remain_q - 1'b1;
    end
  end

  assign byte_o    = word_q[7:0];
  assign lane_last = (lanes_q == LW'(1));
  assign buf_last  = (remain_q == LEN_W'(1));
endmodule

// File: rtl/txdr_ring_reader.sv
`timescale 1ns/1ps
module txdr_ring_reader
  import txdr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic              qp_we_i,
  input  logic [ADDR_W-1:0] qp_data_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic              tx_nocrc_o,
  input  logic              tx_ready_i,
  input  logic              mac_underrun_i,
  input  logic              mac_retry_i
);
  txdr_st_t          st;
  logic [31:0]       ctrl_q;
  logic [31:0]       first_ctrl_q;
  logic [ADDR_W-1:0] bufp_q;
  logic              in_frame_q;
  logic              halt_pend_q;
  logic              urun_q;
  logic              retry_q;

  logic              ptr_load, ptr_adv, mark_first;
  logic [ADDR_W-1:0] buf_word_addr, ctrl_word_addr, first_ctrl_addr;
  logic              pk_len_load, pk_word_load, pk_pop;
  logic [7:0]        pk_byte;
  logic              lane_last, buf_last;
  logic              err_now;
  logic              rd_own;

  assign rd_own      = mem_rdata_i[OWN_B];
  assign ptr_load    = qp_we_i && (st == S_IDLE);
  assign ptr_adv     = (st == S_WB);
  assign mark_first  = (st == S_CWAIT) && !in_frame_q && !rd_own;
  assign pk_len_load = (st == S_AWAIT);
  assign pk_word_load = (st == S_WWAIT);
  assign err_now     = (st == S_SEND) && (mac_underrun_i || mac_retry_i);
  assign pk_pop      = (st == S_SEND) && !err_now && tx_ready_i;

  tdr_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk            (clk),
    .rst            (rst),
    .load_base      (ptr_load),
    .base_in        (qp_data_i),
    .advance        (ptr_adv),
    .wrap           (ctrl_q[WRAP_B]),
    .mark_first     (mark_first),
    .buf_word_addr  (buf_word_addr),
    .ctrl_word_addr (ctrl_word_addr),
    .first_ctrl_addr(first_ctrl_addr)
  );

  tdr_byte_pack #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .load_len (pk_len_load),
    .len_in   (ctrl_q[LEN_W-1:0]),
    .load_word(pk_word_load),
    .word_in  (mem_rdata_i),
    .pop      (pk_pop),
    .byte_o   (pk_byte),
    .lane_last(lane_last),
    .buf_last (buf_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      ctrl_q       <= '0;
      first_ctrl_q <= '0;
      bufp_q       <= '0;
      in_frame_q   <= 1'b0;
      halt_pend_q  <= 1'b0;
      urun_q       <= 1'b0;
      retry_q      <= 1'b0;
    end else begin
      if (halt_i && st != S_IDLE) halt_pend_q <= 1'b1;
      case (st)
        S_IDLE: begin
          halt_pend_q <= 1'b0;
          in_frame_q  <= 1'b0;
          urun_q      <= 1'b0;
          retry_q     <= 1'b0;
          if (start_i) st <= S_CREQ;
        end
        S_CREQ: st <= S_CWAIT;
        S_CWAIT: begin
          if (rd_own) begin
            st <= in_frame_q ? S_EXH : S_IDLE;
          end else if (!in_frame_q && halt_pend_q) begin
            st <= S_IDLE;
          end else begin
            ctrl_q <= mem_rdata_i;
            if (!in_frame_q) first_ctrl_q <= mem_rdata_i;
            st <= S_AREQ;
          end
        end
        S_AREQ: st <= S_AWAIT;
        S_AWAIT: begin
          bufp_q <= ADDR_W'(mem_rdata_i) & ~ADDR_W'(3);
          st <= (ctrl_q[LEN_W-1:0] == '0) ? S_WB : S_WREQ;
        end
        S_WREQ: st <= S_WWAIT;
        S_WWAIT: st <= S_SEND;
        S_SEND: begin
          if (err_now) begin
            urun_q  <= mac_underrun_i;
            retry_q <= mac_retry_i;
            st      <= S_WB;
          end else if (tx_ready_i) begin
            if (buf_last) begin
              st <= S_WB;
            end else if (lane_last) begin
              bufp_q <= bufp_q + ADDR_W'(4);
              st     <= S_WREQ;
            end
          end
        end
        S_WB: begin
          if (urun_q || retry_q) begin
            st <= S_IDLE;
          end else if (ctrl_q[LAST_B]) begin
            in_frame_q <= 1'b0;
            st <= (halt_pend_q || halt_i) ? S_IDLE : S_CREQ;
          end else begin
            in_frame_q <= 1'b1;
            st <= S_CREQ;
          end
        end
        S_EXH: begin
          in_frame_q <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ctrl_word_addr;
    mem_wdata_o = '0;
    case (st)
      S_CREQ: mem_req_o = 1'b1;
      S_AREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = buf_word_addr;
      end
      S_WREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = bufp_q;
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = ctrl_q;
        mem_wdata_o[OWN_B]   = 1'b1;
        mem_wdata_o[URUN_B]  = ctrl_q[URUN_B] | urun_q;
        mem_wdata_o[RETRY_B] = ctrl_q[RETRY_B] | retry_q;
      end
      S_EXH: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = first_ctrl_addr;
        mem_wdata_o = first_ctrl_q;
        mem_wdata_o[OWN_B] = 1'b1;
        mem_wdata_o[EXH_B] = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy_o     = (st != S_IDLE);
  assign tx_valid_o = (st == S_SEND);
  assign tx_data_o  = pk_byte;
  assign tx_last_o  = tx_valid_o && ctrl_q[LAST_B] && buf_last;
  assign tx_nocrc_o = tx_valid_o && first_ctrl_q[NOCRC_B];
endmodule

// File: rtl/txdr_checker.sv
`timescale 1ns/1ps
module txdr_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              tx_last_o,
  input logic              tx_nocrc_o,
  input logic              tx_ready_i,
  input logic              mac_underrun_i,
  input logic              mac_retry_i
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!mem_req_o && !tx_valid_o));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  assert_word_align_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_wb_owned_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[31]);

  assert_urun_stop_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && mac_underrun_i) |=> !tx_valid_o);

  assert_retry_stop_R11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && mac_retry_i) |=> !tx_valid_o);

  assert_byte_hold_R14: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i && !mac_underrun_i && !mac_retry_i) |=>
      (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o) && $stable(tx_nocrc_o)));
endmodule

bind txdr_ring_reader txdr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .mem_wdata_o   (mem_wdata_o),
  .tx_valid_o    (tx_valid_o),
  .tx_data_o     (tx_data_o),
  .tx_last_o     (tx_last_o),
  .tx_nocrc_o    (tx_nocrc_o),
  .tx_ready_i    (tx_ready_i),
  .mac_underrun_i(mac_underrun_i),
  .mac_retry_i   (mac_retry_i)
);

// File: tb/txdr_ring_reader_tb_top.sv
`timescale 1ns/1ps
module txdr_ring_reader_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] OWN   = 32'h8000_0000;
  localparam logic [31:0] WRAP  = 32'h4000_0000;
  localparam logic [31:0] RETRY = 32'h2000_0000;
  localparam logic [31:0] URUN  = 32'h1000_0000;
  localparam logic [31:0] EXH   = 32'h0800_0000;
  localparam logic [31:0] NOCRC = 32'h0001_0000;
  localparam logic [31:0] LAST  = 32'h0000_8000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, halt_i = 1'b0, qp_we_i = 1'b0;
  logic [AW-1:0] qp_data_i = '0;
  logic busy_o, mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic tx_valid_o, tx_last_o, tx_nocrc_o;
  logic [7:0] tx_data_o;
  logic tx_ready_i;
  logic mac_underrun_i = 1'b0, mac_retry_i = 1'b0;

  always #10 clk = ~clk;

  txdr_ring_reader #(.ADDR_W(AW), .IDX_W(10)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .halt_i(halt_i),
    .qp_we_i(qp_we_i), .qp_data_i(qp_data_i), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
    .tx_nocrc_o(tx_nocrc_o), .tx_ready_i(tx_ready_i),
    .mac_underrun_i(mac_underrun_i), .mac_retry_i(mac_retry_i)
  );

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[11:2]];
    if (mem_req_o && mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
  end

  int total = 0;
  int bad = 0;
  int acc_cnt = 0;
  int exp_b[$];
  logic [63:0] exp_w[$];
  string cur_tag = "R4";

  logic rdy_rand = 1'b0;
  logic rdy_force = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign tx_ready_i = rdy_rand ? lfsr[0] : rdy_force;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model queues
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (!rst && tx_valid_o && tx_ready_i) begin
        acc_cnt++;
        if (exp_b.size() == 0) chk(0, {cur_tag, " unexpected byte"}, {tx_nocrc_o, tx_last_o, tx_data_o}, 0);
        else begin
          int e;
          e = exp_b.pop_front();
          chk({22'd0, tx_nocrc_o, tx_last_o, tx_data_o} == e, {cur_tag, " byte"},
              {tx_nocrc_o, tx_last_o, tx_data_o}, e);
        end
      end
      if (!rst && mem_req_o && mem_we_o) begin
        if (exp_w.size() == 0) chk(0, {cur_tag, " unexpected write"}, {mem_addr_o, mem_wdata_o}, 0);
        else begin
          logic [63:0] w;
          w = exp_w.pop_front();
          chk({mem_addr_o, mem_wdata_o} == w, {cur_tag, " writeback"}, {mem_addr_o, mem_wdata_o}, w);
        end
      end
    end
  end

  function automatic int wi(input int a);
    return (a >> 2) & 1023;
  endfunction

  task automatic put_desc(input int base, input int idx, input int ba, input logic [31:0] ctrl);
    mem[wi(base + 8*idx)]     = ba;
    mem[wi(base + 8*idx + 4)] = ctrl;
  endtask

  task automatic fill(input int a, input int len, input int seed);
    for (int i = 0; i < len; i++) mem[wi(a+i)][8*((a+i)&3) +: 8] = 8'((seed + 13*i) & 255);
  endtask

  // R4: bytes in address order, low byte of a word first
  task automatic exp_bytes(input int a, input int cnt, input int len, input bit last, input bit nocrc);
    for (int i = 0; i < cnt; i++)
      exp_b.push_back({nocrc, (last && i == len-1), mem[wi(a+i)][8*((a+i)&3) +: 8]});
  endtask

  task automatic exp_wr(input int a, input logic [31:0] d);
    exp_w.push_back({32'(a), d});
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic write_qp(input int a);
    @(negedge clk); qp_we_i = 1'b1; qp_data_i = a; @(negedge clk); qp_we_i = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    while (busy_o && n < 2000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    chk(!busy_o, {tag, " busy low at end"}, busy_o, 0);
    chk(exp_b.size() == 0, {tag, " all bytes seen"}, exp_b.size(), 0);
    chk(exp_w.size() == 0, {tag, " all writes seen"}, exp_w.size(), 0);
    exp_b.delete();
    exp_w.delete();
  endtask

  task automatic wait_acc(input int n);
    while (acc_cnt < n) @(negedge clk);
  endtask

  bit fin = 0;
  initial begin
    #(20 * 150000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = OWN;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy_o, "R1 busy after reset", busy_o, 0);
    chk(!tx_valid_o, "R1 tx_valid after reset", tx_valid_o, 0);
    chk(!mem_req_o, "R1 mem_req after reset", mem_req_o, 0);

    write_qp(32'h100);

    // R2 R4 R5 R7: one single-buffer frame, then an owned entry
    cur_tag = "R7";
    put_desc(32'h100, 0, 32'h400, LAST | 32'd5);
    put_desc(32'h100, 1, 32'h0, OWN);
    fill(32'h400, 5, 3);
    exp_bytes(32'h400, 5, 5, 1, 0);
    exp_wr(32'h104, OWN | LAST | 32'd5);
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    chk(busy_o, "R2 busy after start", busy_o, 1);
    wait_idle("R2");

    // R5 R6 R14: two-buffer frame with no-CRC, ready stalls randomly
    cur_tag = "R6";
    rdy_rand = 1'b1;
    put_desc(32'h100, 1, 32'h480, NOCRC | 32'd4);
    put_desc(32'h100, 2, 32'h4C0, LAST | 32'd6);
    put_desc(32'h100, 3, 32'h0, OWN);
    fill(32'h480, 4, 50);
    fill(32'h4C0, 6, 90);
    exp_bytes(32'h480, 4, 4, 0, 1);
    exp_bytes(32'h4C0, 6, 6, 1, 1);
    exp_wr(32'h10C, OWN | NOCRC | 32'd4);
    exp_wr(32'h114, OWN | LAST | 32'd6);
    pulse_start();
    wait_idle("R5");
    rdy_rand = 1'b0;

    // R4 R8: zero-length buffer on the wrap entry, then entry 0 is owned
    cur_tag = "R8";
    put_desc(32'h100, 3, 32'h500, WRAP | LAST);
    exp_wr(32'h11C, OWN | WRAP | LAST);
    pulse_start();
    wait_idle("R8 zero-length");
    // R8: next start fetches entry 0
    put_desc(32'h100, 0, 32'h540, LAST | 32'd3);
    put_desc(32'h100, 1, 32'h0, OWN);
    fill(32'h540, 3, 7);
    exp_bytes(32'h540, 3, 3, 1, 0);
    exp_wr(32'h104, OWN | LAST | 32'd3);
    pulse_start();
    wait_idle("R8 wrap to 0");

    // R13: queue pointer write while idle resets index
    cur_tag = "R13";
    write_qp(32'h200);
    put_desc(32'h200, 0, 32'h600, LAST | 32'd7);
    put_desc(32'h200, 1, 32'h0, OWN);
    fill(32'h600, 7, 21);
    exp_bytes(32'h600, 7, 7, 1, 0);
    exp_wr(32'h204, OWN | LAST | 32'd7);
    pulse_start();
    wait_idle("R13 idle write");

    // R9: ring runs out mid frame
    cur_tag = "R9";
    put_desc(32'h200, 1, 32'h640, 32'd3);
    put_desc(32'h200, 2, 32'h0, OWN);
    fill(32'h640, 3, 44);
    exp_bytes(32'h640, 3, 3, 0, 0);
    exp_wr(32'h20C, OWN | 32'd3);
    exp_wr(32'h20C, OWN | EXH | 32'd3);
    pulse_start();
    wait_idle("R9");

    // R10: underrun mid word during a stall
    cur_tag = "R10";
    write_qp(32'h300);
    put_desc(32'h300, 0, 32'h700, LAST | 32'd8);
    put_desc(32'h300, 1, 32'h720, LAST | 32'd4);
    fill(32'h700, 8, 60);
    exp_bytes(32'h700, 2, 8, 1, 0);
    exp_wr(32'h304, OWN | URUN | LAST | 32'd8);
    acc_cnt = 0;
    pulse_start();
    wait_acc(2);
    rdy_force = 1'b0;
    repeat (2) @(negedge clk);
    mac_underrun_i = 1'b1;
    @(negedge clk);
    mac_underrun_i = 1'b0;
    rdy_force = 1'b1;
    wait_idle("R10");
    chk(mem[wi(32'h30C)] == (LAST | 32'd4), "R10 next descriptor untouched", mem[wi(32'h30C)], LAST | 32'd4);

    // R11: retry limit mid word
    cur_tag = "R11";
    write_qp(32'h300);
    put_desc(32'h300, 0, 32'h740, LAST | 32'd6);
    fill(32'h740, 6, 77);
    exp_bytes(32'h740, 3, 6, 1, 0);
    exp_wr(32'h304, OWN | RETRY | LAST | 32'd6);
    acc_cnt = 0;
    pulse_start();
    wait_acc(3);
    rdy_force = 1'b0;
    @(negedge clk);
    mac_retry_i = 1'b1;
    @(negedge clk);
    mac_retry_i = 1'b0;
    rdy_force = 1'b1;
    wait_idle("R11");

    // R12 R13: halt and a busy-time pointer write during a frame
    cur_tag = "R12";
    write_qp(32'h380);
    put_desc(32'h380, 0, 32'h780, LAST | 32'd12);
    put_desc(32'h380, 1, 32'h7C0, LAST | 32'd4);
    put_desc(32'h380, 2, 32'h0, OWN);
    fill(32'h780, 12, 5);
    fill(32'h7C0, 4, 111);
    exp_bytes(32'h780, 12, 12, 1, 0);
    exp_wr(32'h384, OWN | LAST | 32'd12);
    pulse_start();
    repeat (3) @(negedge clk);
    halt_i = 1'b1; qp_we_i = 1'b1; qp_data_i = 32'h000;
    @(negedge clk);
    halt_i = 1'b0; qp_we_i = 1'b0;
    wait_idle("R12 halt");
    chk(mem[wi(32'h38C)] == (LAST | 32'd4), "R12 next descriptor untouched", mem[wi(32'h38C)], LAST | 32'd4);
    cur_tag = "R13";
    exp_bytes(32'h7C0, 4, 4, 1, 0);
    exp_wr(32'h38C, OWN | LAST | 32'd4);
    pulse_start();
    wait_idle("R13 busy write ignored");

    // R3: start on an owned entry does nothing
    cur_tag = "R3";
    pulse_start();
    wait_idle("R3");
    chk(mem[wi(32'h394)] == OWN, "R3 owned entry unchanged", mem[wi(32'h394)], OWN);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule